// File: doc/BRIEF.md
# CompactFlash True IDE Bus Cycle Generator

This block turns a single host request into one CompactFlash True IDE register access on an external static memory bus. The host supplies a three-bit register index, a window select (main register window or alternate status/control window), a read/write flag, a width flag and write data through a valid/acknowledge port. The block then drives chip select, a read or write strobe, the address (with the card mode lines in the upper bits), the write data lanes and their output enable. It samples the card's IORDY line and the incoming data bus.

The 8-bit task file and the 16-bit data register share one address, and only the access width tells them apart. Byte accesses use data lanes [7:0] only. Halfword accesses use all 16 lines. The timing comes from four 8-bit counts, given in clock cycles: strobe setup, strobe pulse, total cycle and data-float turnaround. An IORDY enable lets the card stretch the strobe. All timing inputs are latched when a request is accepted, so changing them during an access has no effect on that access.

Top module: `cfide_bus_master`

## Requirements
- R1: While reset is held and in the first cycle after it, `bus_cs_n`, `bus_rd_n` and `bus_wr_n` are 1, and `bus_dq_oe`, `ack` and `rdata` are 0.
- R2: During an access `bus_addr[23:21]` is 3'b110 when `req_alt`=0 and 3'b111 when `req_alt`=1. `bus_addr[2:0]` equals `req_addr`. Every other address bit is 0. The address does not change while chip select is low.
- R3: A request seen with `req_valid`=1 while the block is idle is accepted at that clock edge. Chip select is then low for exactly Ceff consecutive cycles, starting in the cycle right after acceptance.
- R4: Counting the cycles of chip select low from 0, the strobe for the access (`bus_rd_n` for a read, `bus_wr_n` for a write) is low in cycles S to S+Peff-1. The other strobe stays high for the whole access.
- R5: Peff = max(P,1) and Ceff = max(C, S+Peff+1), where S, P and C are the setup, pulse and cycle counts.
- R6: When `cfg_iordy_en`=1, each strobe cycle in which `bus_iordy`=0 adds one cycle to both the strobe and the chip select time. When `cfg_iordy_en`=0, `bus_iordy` has no effect on any output.
- R7: Read data is captured from `bus_dq_in` at the clock edge that ends the last strobe cycle, and is held on `rdata` until the next read capture. A byte read returns {8'h00, bus_dq_in[7:0]}. A halfword read returns all 16 bits.
- R8: For a write, `bus_dq_oe` is 1 in every chip-select-low cycle and 0 at all other times. `bus_dq_out` is the write data for a halfword write and {8'h00, wdata[7:0]} for a byte write. `bus_dq_oe` is never 1 during a read.
- R9: `ack` is 1 for exactly one cycle: the cycle right after the last chip-select-low cycle, with chip select already high.
- R10: After a read with a float count F>0, the block stays busy for F more cycles after the `ack` cycle. After a write, or when F=0, it is idle in the cycle after `ack`.
- R11: A request held valid during an access, its `ack` cycle or its float period is ignored. With `req_valid` held high, the next chip select low appears F+2 cycles after `ack` for a read with F>0, and 2 cycles after `ack` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit data register access, 0 = 8-bit register access |
| req_alt | input | 1 | 1 = alternate status/control window, 0 = main register window |
| req_addr | input | 3 | Register index within the window |
| req_wdata | input | 16 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Last captured read data |
| cfg_setup | input | 8 | Strobe setup count S |
| cfg_pulse | input | 8 | Strobe pulse count P |
| cfg_cycle | input | 8 | Total cycle count C |
| cfg_float | input | 8 | Data-float count F after reads |
| cfg_iordy_en | input | 1 | Enable IORDY strobe stretching |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_addr | output | 24 | Bus address including mode lines [23:21] |
| bus_dq_out | output | 16 | Write data to the bus |
| bus_dq_oe | output | 1 | Data output enable |
| bus_dq_in | input | 16 | Read data from the bus |
| bus_iordy | input | 1 | Card ready, low stretches the strobe |

## Verification
The main timing is tried with several patterns. A plain setup/pulse/cycle set places the strobe window and the ack. A cycle count that is too short, together with a zero pulse, exercises the clamp. Each combination of byte or halfword width with read or write direction, in both windows, shows whether the data lanes, zero extension and mode lines follow the request. The same IORDY low burst is applied with stretching enabled and with it disabled, so that stretching is separated from an IORDY line that is ignored. Holding the request valid across reads and writes, with and without a float count, shows the difference between float turnaround after reads and the immediate restart after writes.

// File: rtl/cfide_pkg.sv
// Package: shared state encoding and card mode codes for the True IDE
// cycle generator. Assumes the mode field is three bits wide.
package cfide_pkg;

    localparam int MODE_W = 3;

    // Upper address mode codes: main register window and alternate window
    localparam logic [MODE_W-1:0] MODE_TASKFILE = 3'b110;
    localparam logic [MODE_W-1:0] MODE_ALTSTAT  = 3'b111;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_ACK    = 2'd2,
        ST_FLOAT  = 2'd3
    } cf_state_e;

endpackage

// File: rtl/cfide_timing_clamp.sv
// Module: cfide_timing_clamp
// Converts raw setup/pulse/cycle counts into the effective strobe window
// and total cycle length. The pulse is forced to at least one cycle, and
// the cycle to at least setup+pulse+1, so the strobe always ends before
// chip select. Purely combinational; the inputs are assumed to be held
// stable by the caller for the whole access.
module cfide_timing_clamp #(
    parameter int CNT_W = 8,
    localparam int TW   = CNT_W + 1
) (
    input  logic [CNT_W-1:0] raw_setup,
    input  logic [CNT_W-1:0] raw_pulse,
    input  logic [CNT_W-1:0] raw_cycle,
    output logic [TW-1:0]    strb_start,
    output logic [TW-1:0]    strb_end,
    output logic [TW-1:0]    cyc_len
);

    logic [TW-1:0] pulse_eff;
    logic [TW-1:0] min_cycle;

    // Clamp the pulse and derive the strobe window and minimum cycle
    always_comb begin
        pulse_eff  = (raw_pulse == '0) ? TW'(1) : TW'(raw_pulse);
        strb_start = TW'(raw_setup);
        strb_end   = strb_start + pulse_eff;
        min_cycle  = strb_end + TW'(1);
        cyc_len    = (TW'(raw_cycle) < min_cycle) ? min_cycle : TW'(raw_cycle);
    end

endmodule

// File: rtl/cfide_addr_map.sv
// Module: cfide_addr_map
// Builds the external bus address from the window select and register
// index. The mode code sits in the top MODE_W bits, the register index in
// the low REG_AW bits, and everything in between is zero.
// Assumes ADDR_W > MODE_W + REG_AW.
module cfide_addr_map
    import cfide_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int REG_AW = 3,
    localparam int GAP_W = ADDR_W - MODE_W - REG_AW
) (
    input  logic              alt_sel,
    input  logic [REG_AW-1:0] reg_idx,
    output logic [ADDR_W-1:0] bus_address
);

    logic [MODE_W-1:0] mode_code;

    // Pick the mode code and assemble the full address
    always_comb begin
        mode_code   = alt_sel ? MODE_ALTSTAT : MODE_TASKFILE;
        bus_address = {mode_code, {GAP_W{1'b0}}, reg_idx};
    end

endmodule

// File: rtl/cfide_lane_mux.sv
// Module: cfide_lane_mux
// Byte-lane steering for both directions. Lane 0 always passes through.
// Upper lanes pass only for a wide (data register) access and read as
// zero otherwise, which gives zero extension on reads and quiet upper
// lanes on byte writes.
module cfide_lane_mux #(
    parameter int DATA_W = 16,
    parameter int LANE_W = 8,
    localparam int NLANES = DATA_W / LANE_W
) (
    input  logic              wide,
    input  logic [DATA_W-1:0] wr_src,
    input  logic [DATA_W-1:0] rd_src,
    output logic [DATA_W-1:0] wr_lanes,
    output logic [DATA_W-1:0] rd_lanes
);

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        if (g == 0) begin : g_low
            // Low lane is used by every access width
            always_comb begin
                wr_lanes[LANE_W-1:0] = wr_src[LANE_W-1:0];
                rd_lanes[LANE_W-1:0] = rd_src[LANE_W-1:0];
            end
        end else begin : g_high
            // Upper lanes are gated by the access width
            always_comb begin
                wr_lanes[g*LANE_W +: LANE_W] = wide ? wr_src[g*LANE_W +: LANE_W] : '0;
                rd_lanes[g*LANE_W +: LANE_W] = wide ? rd_src[g*LANE_W +: LANE_W] : '0;
            end
        end
    end

endmodule

// File: rtl/cfide_seq.sv
// Module: cfide_seq
// Access sequencer: idle, access (chip select low, strobe window inside),
// one ack cycle, then an optional float wait after reads. The cycle
// counter freezes during the strobe while IORDY stretching is enabled and
// the card holds IORDY low. IORDY is assumed to be synchronous to clk.
module cfide_seq
    import cfide_pkg::*;
#(
    parameter int CNT_W = 8,
    localparam int TW   = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             is_read,
    input  logic [TW-1:0]    strb_start,
    input  logic [TW-1:0]    strb_end,
    input  logic [TW-1:0]    cyc_len,
    input  logic [CNT_W-1:0] flt_len,
    input  logic             iordy_en,
    input  logic             iordy,
    output logic             idle,
    output logic             cs_act,
    output logic             strobe_act,
    output logic             capture,
    output logic             ack_pulse
);

    cf_state_e        state;
    logic [TW-1:0]    cnt;
    logic [CNT_W-1:0] fcnt;
    logic             stall;
    logic             last_cyc;

    // Decode phase outputs from state and counter
    always_comb begin
        idle       = (state == ST_IDLE);
        cs_act     = (state == ST_ACCESS);
        ack_pulse  = (state == ST_ACK);
        strobe_act = cs_act && (cnt >= strb_start) && (cnt < strb_end);
        stall      = strobe_act && iordy_en && !iordy;
        capture    = strobe_act && !stall && is_read && (cnt == strb_end - TW'(1));
        last_cyc   = (cnt == cyc_len - TW'(1));
    end

    // Advance the state machine and the cycle and float counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            fcnt  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_ACCESS;
                        cnt   <= '0;
                    end
                end
                ST_ACCESS: begin
                    if (!stall) begin
                        if (last_cyc) begin
                            state <= ST_ACK;
                        end else begin
                            cnt <= cnt + TW'(1);
                        end
                    end
                end
                ST_ACK: begin
                    if (is_read && (flt_len != '0)) begin
                        state <= ST_FLOAT;
                        fcnt  <= flt_len - CNT_W'(1);
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_FLOAT: begin
                    if (fcnt == '0) begin
                        state <= ST_IDLE;
                    end else begin
                        fcnt <= fcnt - CNT_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cfide_bus_master.sv
// Module: cfide_bus_master
// Top of the True IDE cycle generator. Accepts one host request while idle,
// latches it together with the timing configuration, and lets the
// sequencer run the bus cycle. Chip select has zero setup. Read data is
// captured into a holding register at the end of the strobe. Assumes the
// host waits for ack before expecting data and that the bus signals share clk.
module cfide_bus_master #(
    parameter int CNT_W  = 8,
    parameter int DATA_W = 16,
    parameter int LANE_W = 8,
    parameter int ADDR_W = 24,
    parameter int REG_AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic              req_alt,
    input  logic [REG_AW-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    input  logic [CNT_W-1:0]  cfg_setup,
    input  logic [CNT_W-1:0]  cfg_pulse,
    input  logic [CNT_W-1:0]  cfg_cycle,
    input  logic [CNT_W-1:0]  cfg_float,
    input  logic              cfg_iordy_en,
    output logic              bus_cs_n,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dq_out,
    output logic              bus_dq_oe,
    input  logic [DATA_W-1:0] bus_dq_in,
    input  logic              bus_iordy
);

    localparam int TW = CNT_W + 1;

    // Latched request and configuration
    logic              wr_q, wide_q, alt_q, iordy_en_q;
    logic [REG_AW-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [CNT_W-1:0]  setup_q, pulse_q, cycle_q, float_q;

    logic              start, idle, cs_act, strobe_act, capture, ack_pulse;
    logic [TW-1:0]     strb_start, strb_end, cyc_len;
    logic [DATA_W-1:0] wr_lanes, rd_lanes;

    // Accept only while idle
    always_comb start = idle && req_valid;

    // Latch the request and its timing at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q       <= 1'b0;
            wide_q     <= 1'b0;
            alt_q      <= 1'b0;
            addr_q     <= '0;
            wdata_q    <= '0;
            setup_q    <= '0;
            pulse_q    <= CNT_W'(1);
            cycle_q    <= '0;
            float_q    <= '0;
            iordy_en_q <= 1'b0;
        end else if (start) begin
            wr_q       <= req_write;
            wide_q     <= req_wide;
            alt_q      <= req_alt;
            addr_q     <= req_addr;
            wdata_q    <= req_wdata;
            setup_q    <= cfg_setup;
            pulse_q    <= cfg_pulse;
            cycle_q    <= cfg_cycle;
            float_q    <= cfg_float;
            iordy_en_q <= cfg_iordy_en;
        end
    end

    cfide_timing_clamp #(.CNT_W(CNT_W)) u_clamp (
        .raw_setup  (setup_q),
        .raw_pulse  (pulse_q),
        .raw_cycle  (cycle_q),
        .strb_start (strb_start),
        .strb_end   (strb_end),
        .cyc_len    (cyc_len)
    );

    cfide_seq #(.CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .is_read    (!wr_q),
        .strb_start (strb_start),
        .strb_end   (strb_end),
        .cyc_len    (cyc_len),
        .flt_len    (float_q),
        .iordy_en   (iordy_en_q),
        .iordy      (bus_iordy),
        .idle       (idle),
        .cs_act     (cs_act),
        .strobe_act (strobe_act),
        .capture    (capture),
        .ack_pulse  (ack_pulse)
    );

    cfide_addr_map #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_amap (
        .alt_sel     (alt_q),
        .reg_idx     (addr_q),
        .bus_address (bus_addr)
    );

    cfide_lane_mux #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_lanes (
        .wide     (wide_q),
        .wr_src   (wdata_q),
        .rd_src   (bus_dq_in),
        .wr_lanes (wr_lanes),
        .rd_lanes (rd_lanes)
    );

    // Hold the captured read data until the next read completes its strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (capture) begin
            rdata <= rd_lanes;
        end
    end

    // Drive the bus controls from the sequencer phase
    always_comb begin
        bus_cs_n   = !cs_act;
        bus_rd_n   = !(strobe_act && !wr_q);
        bus_wr_n   = !(strobe_act && wr_q);
        bus_dq_oe  = cs_act && wr_q;
        bus_dq_out = wr_lanes;
        ack        = ack_pulse;
    end

endmodule

// File: rtl/cfide_bus_master_chk.sv
// Module: cfide_bus_master_chk
// Port-level protocol checks for cfide_bus_master, attached by bind.
module cfide_bus_master_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack,
    input logic [DATA_W-1:0] rdata,
    input logic              bus_cs_n,
    input logic              bus_rd_n,
    input logic              bus_wr_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_dq_oe
);

    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cs_n |-> (bus_rd_n && bus_wr_n)); // R3

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n)); // R4

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R9

    AST_ACK_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (bus_cs_n && $past(!bus_cs_n))); // R9

    AST_OE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dq_oe |-> (!bus_cs_n && bus_rd_n)); // R8

    AST_MODE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cs_n |-> (bus_addr[ADDR_W-1 -: 2] == 2'b11)); // R2

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && $past(!bus_cs_n)) |-> $stable(bus_addr)); // R2

    AST_RDATA_AT_STROBE_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata) |-> ($past(!bus_rd_n) && bus_rd_n)); // R7

endmodule

bind cfide_bus_master cfide_bus_master_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack       (ack),
    .rdata     (rdata),
    .bus_cs_n  (bus_cs_n),
    .bus_rd_n  (bus_rd_n),
    .bus_wr_n  (bus_wr_n),
    .bus_addr  (bus_addr),
    .bus_dq_oe (bus_dq_oe)
);

// File: tb/cfide_bus_master_tb.sv
// Directed bench for cfide_bus_master: one task per scenario.
module cfide_bus_master_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0, req_alt = 1'b0;
    logic [2:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        ack;
    logic [15:0] rdata;
    logic [7:0]  cfg_setup = 8'd2, cfg_pulse = 8'd3, cfg_cycle = 8'd8, cfg_float = 8'd0;
    logic        cfg_iordy_en = 1'b0;
    logic        bus_cs_n, bus_rd_n, bus_wr_n, bus_dq_oe;
    logic [23:0] bus_addr;
    logic [15:0] bus_dq_out;
    logic [15:0] bus_dq_in = 16'hDEAD;
    logic        bus_iordy = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    // Results of the last access
    int          cs_cnt, rd_first, rd_len, wr_first, wr_len, oe_cnt, ack_idx, next_cs, acks;
    logic [23:0] addr_seen;
    logic [15:0] dq_seen, rd_seen;

    always #10 clk = ~clk;

    cfide_bus_master u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_wide(req_wide),
        .req_alt(req_alt), .req_addr(req_addr), .req_wdata(req_wdata),
        .ack(ack), .rdata(rdata),
        .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse), .cfg_cycle(cfg_cycle),
        .cfg_float(cfg_float), .cfg_iordy_en(cfg_iordy_en),
        .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_addr(bus_addr), .bus_dq_out(bus_dq_out), .bus_dq_oe(bus_dq_oe),
        .bus_dq_in(bus_dq_in), .bus_iordy(bus_iordy)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
            finish_run();
        end
    end

    // Run one access and record what the bus did; iw = IORDY low cycles from strobe start
    task automatic run_access(input logic wr, input logic wide, input logic alt,
                              input logic [2:0] a, input logic [15:0] wd,
                              input logic [15:0] rdin, input int iw, input bit hold,
                              input int flt);
        cs_cnt = 0; rd_first = -1; rd_len = 0; wr_first = -1; wr_len = 0;
        oe_cnt = 0; ack_idx = -1; next_cs = -1; acks = 0;
        addr_seen = '0; dq_seen = '0; rd_seen = '0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_wide = wide; req_alt = alt;
        req_addr = a; req_wdata = wd;
        @(posedge clk);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!hold) req_valid = 1'b0;
            if (acks == 0) begin
                if (!bus_cs_n) begin
                    if (cs_cnt == 0) addr_seen = bus_addr;
                    cs_cnt++;
                end
                if (!bus_rd_n) begin
                    if (rd_first < 0) rd_first = i;
                    rd_len++;
                end
                if (!bus_wr_n) begin
                    if (wr_first < 0) wr_first = i;
                    wr_len++;
                    dq_seen = bus_dq_out;
                end
                if (bus_dq_oe) oe_cnt++;
            end
            if (ack) begin
                acks++;
                if (acks == 1) begin
                    ack_idx = i;
                    rd_seen = rdata;
                end
            end
            if (acks >= 1 && !bus_cs_n && next_cs < 0 && i > ack_idx) begin
                next_cs = i;
                req_valid = 1'b0;
            end
            bus_iordy = !(iw > 0 && rd_first >= 0 && i >= rd_first && i < rd_first + iw);
            bus_dq_in = !bus_rd_n ? rdin : 16'hDEAD;
            if (acks >= 1 && i >= ack_idx + flt + 4 && (!hold || acks >= 2)) break;
        end
        req_valid = 1'b0;
        bus_iordy = 1'b1;
    endtask

    task automatic set_cfg(input int s, input int p, input int c, input int f, input logic ie);
        cfg_setup = 8'(s); cfg_pulse = 8'(p); cfg_cycle = 8'(c);
        cfg_float = 8'(f); cfg_iordy_en = ie;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 cs_n in reset", bus_cs_n, 1);
        chk("R1 strobes in reset", {bus_rd_n, bus_wr_n}, 2'b11);
        chk("R1 oe/ack in reset", {bus_dq_oe, ack}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {bus_cs_n, bus_rd_n, bus_wr_n, bus_dq_oe, ack}, 5'b11100);
        chk("R1 rdata after reset", rdata, 0);
    endtask

    task automatic t_byte_read();
        set_cfg(2, 3, 8, 0, 1'b0);
        run_access(1'b0, 1'b0, 1'b0, 3'd7, 16'h0, 16'h12AB, 0, 1'b0, 0);
        chk("R2 task file address", addr_seen, 24'hC00007);
        chk("R3 cs length", cs_cnt, 8);
        chk("R4 rd start", rd_first, 2);
        chk("R4 rd length", rd_len, 3);
        chk("R4 no wr on read", wr_len, 0);
        chk("R8 no oe on read", oe_cnt, 0);
        chk("R9 ack position", ack_idx, 8);
        chk("R7 byte read zero extended", rd_seen, 16'h00AB);
    endtask

    task automatic t_wide_write();
        set_cfg(1, 4, 9, 0, 1'b0);
        run_access(1'b1, 1'b1, 1'b0, 3'd0, 16'hA55A, 16'h0, 0, 1'b0, 0);
        chk("R2 data register address", addr_seen, 24'hC00000);
        chk("R4 wr start", wr_first, 1);
        chk("R4 wr length", wr_len, 4);
        chk("R4 no rd on write", rd_len, 0);
        chk("R8 wide write data", dq_seen, 16'hA55A);
        chk("R8 oe over whole cs", oe_cnt, 9);
        chk("R9 ack after write", ack_idx, 9);
        chk("R7 rdata held over write", rdata, 16'h00AB);
    endtask

    task automatic t_byte_write_alt();
        set_cfg(2, 3, 8, 0, 1'b0);
        run_access(1'b1, 1'b0, 1'b1, 3'd6, 16'h1234, 16'h0, 0, 1'b0, 0);
        chk("R2 alternate window address", addr_seen, 24'hE00006);
        chk("R8 byte write lanes", dq_seen, 16'h0034);
    endtask

    task automatic t_wide_read_alt();
        set_cfg(3, 2, 10, 0, 1'b0);
        run_access(1'b0, 1'b1, 1'b1, 3'd2, 16'h0, 16'hBEEF, 0, 1'b0, 0);
        chk("R2 alternate read address", addr_seen, 24'hE00002);
        chk("R7 wide read data", rd_seen, 16'hBEEF);
        chk("R3 cs length 10", cs_cnt, 10);
    endtask

    task automatic t_clamp();
        set_cfg(2, 0, 1, 0, 1'b0);
        run_access(1'b0, 1'b0, 1'b0, 3'd1, 16'h0, 16'h0055, 0, 1'b0, 0);
        chk("R5 pulse clamped to 1", rd_len, 1);
        chk("R5 cycle clamped to S+P+1", cs_cnt, 4);
        chk("R5 ack after clamped cycle", ack_idx, 4);
        chk("R7 clamped read data", rd_seen, 16'h0055);
    endtask

    task automatic t_iordy_on();
        set_cfg(2, 3, 8, 0, 1'b1);
        run_access(1'b0, 1'b1, 1'b0, 3'd0, 16'h0, 16'hC0DE, 4, 1'b0, 0);
        chk("R6 stretched strobe", rd_len, 7);
        chk("R6 stretched cs", cs_cnt, 12);
        chk("R6 stretched ack", ack_idx, 12);
        chk("R6 read data after stretch", rd_seen, 16'hC0DE);
    endtask

    task automatic t_iordy_off();
        set_cfg(2, 3, 8, 0, 1'b0);
        run_access(1'b0, 1'b1, 1'b0, 3'd0, 16'h0, 16'h4321, 4, 1'b0, 0);
        chk("R6 iordy ignored strobe", rd_len, 3);
        chk("R6 iordy ignored cs", cs_cnt, 8);
    endtask

    task automatic t_float_hold();
        set_cfg(2, 3, 8, 3, 1'b0);
        run_access(1'b0, 1'b0, 1'b0, 3'd7, 16'h0, 16'h0011, 0, 1'b1, 3);
        chk("R10 R11 restart after read float", next_cs, ack_idx + 5);
        set_cfg(2, 3, 8, 0, 1'b0);
        run_access(1'b0, 1'b0, 1'b0, 3'd7, 16'h0, 16'h0022, 0, 1'b1, 0);
        chk("R10 R11 restart after read no float", next_cs, ack_idx + 2);
        set_cfg(2, 3, 8, 3, 1'b0);
        run_access(1'b1, 1'b0, 1'b0, 3'd3, 16'h0077, 16'h0, 0, 1'b1, 3);
        chk("R10 R11 no float after write", next_cs, ack_idx + 2);
    endtask

    initial begin
        t_reset();
        t_byte_read();
        t_wide_write();
        t_byte_write_alt();
        t_wide_read_alt();
        t_clamp();
        t_iordy_on();
        t_iordy_off();
        t_float_hold();
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule